// File: doc/BRIEF.md
# GPIO Port Control Register Bank

This block is the control register file for one port of general-purpose pins. It sits on a simple 32-bit memory-mapped bus made of a byte address, a write strobe, write data and read data. For every pin it holds five settings: whether the pin is plain GPIO or given to a peripheral, which of two peripheral functions is chosen, whether the output driver is on, the output level, and whether the pin is connected to the input path. It drives the pad output level, the pad output enable and the two function-select vectors straight from those registers.

The function select, output enable, output level and peripheral choice each have two extra addresses. A write of ones to the set address turns the matching bits on. A write of ones to the clear address turns them off. Software can therefore change one pin without reading the register first. Pin levels pass through a two-flop synchronizer and can be read at the input address, masked by the connect enable. Pull and drive-strength settings are stored here and read back, but they have no effect inside the block. Writes take effect at the clock edge that samples them. Reads are combinational from the current address.

Top module: `pin_ctrl_bank`

## Requirements
- R1: After reset the function-select register (0x00) reads 0xFFFFFFFF and `pin_gpio` is all ones. Every other register reads 0, and `pad_out`, `pad_oe` and `pin_alt_sec` are 0.
- R2: A write with `wr_en`=1 to a base address loads `wdata` at the sampling edge, and the register reads back the new value. The base addresses are 0x00 function select, 0x0C output enable, 0x18 output level, 0x30 input connect and 0x68 peripheral choice. The outputs take the new value too: `pin_gpio` gets 0x00 (1 = GPIO, 0 = peripheral), `pad_oe` gets 0x0C (1 = driving), `pad_out` gets 0x18, and `pin_alt_sec` gets 0x68 (0 = primary, 1 = secondary).
- R3: A write to a set address ORs `wdata` into its base register, and bits written 0 are kept. The set addresses are 0x04 for 0x00, 0x10 for 0x0C, 0x1C for 0x18 and 0x6C for 0x68.
- R4: A write to a clear address clears every base bit where `wdata` is 1, and other bits are kept. The clear addresses are 0x08 for 0x00, 0x14 for 0x0C, 0x20 for 0x18 and 0x70 for 0x68.
- R5: The output-level set and clear addresses (0x1C, 0x20) read as 0. The other set and clear addresses read back their base register.
- R6: Address 0x24 returns the pin levels after two rising edges of synchronization. A level applied before edge k is readable after edge k+1 and not after edge k. Writes to 0x24 change nothing.
- R7: In the value read at 0x24, every bit whose input-connect bit (0x30) is 0 reads 0.
- R8: Addresses 0x60, 0x64, 0xB0, 0xB4 and 0xB8 are plain 32-bit read/write storage. Writing them leaves all pad and select outputs unchanged.
- R9: Every other address reads 0, including reserved 0x44, 0x58, 0x74–0xAF and non-word-aligned addresses. Writes to these addresses change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Byte address of the access |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pad_out | output | 32 | Pad output level |
| pad_oe | output | 32 | Pad output enable, 1 = driving |
| pin_gpio | output | 32 | Per pin: 1 = GPIO, 0 = peripheral function |
| pin_alt_sec | output | 32 | Per pin: 0 = primary, 1 = secondary peripheral |

## Verification
A write sampled at a rising edge shows on the pad outputs and on the combinational read data right after that edge. The checks therefore sample at the falling edge that follows the write cycle. Pin levels need two edges, so the bench checks the input address after one edge, where the old value must still be present, and again after the second edge, where the new value must appear. All inputs are driven and all outputs sampled at falling edges. No check depends on the order of processes at a rising edge.

// File: rtl/pin_ctrl_pkg.sv
package pin_ctrl_pkg;
    localparam logic [7:0] OFS_FN      = 8'h00;
    localparam logic [7:0] OFS_FN_SET  = 8'h04;
    localparam logic [7:0] OFS_FN_CLR  = 8'h08;
    localparam logic [7:0] OFS_OE      = 8'h0C;
    localparam logic [7:0] OFS_OE_SET  = 8'h10;
    localparam logic [7:0] OFS_OE_CLR  = 8'h14;
    localparam logic [7:0] OFS_OUT     = 8'h18;
    localparam logic [7:0] OFS_OUT_SET = 8'h1C;
    localparam logic [7:0] OFS_OUT_CLR = 8'h20;
    localparam logic [7:0] OFS_IN      = 8'h24;
    localparam logic [7:0] OFS_INCONN  = 8'h30;
    localparam logic [7:0] OFS_ALT     = 8'h68;
    localparam logic [7:0] OFS_ALT_SET = 8'h6C;
    localparam logic [7:0] OFS_ALT_CLR = 8'h70;

    // plain storage words: pull selects, drive strengths, pull mode
    localparam int NSTORE = 5;
    localparam logic [7:0] STORE_OFS [NSTORE] = '{8'h60, 8'h64, 8'hB0, 8'hB4, 8'hB8};

    // write strobes for one register with set and clear aliases
    typedef struct packed {
        logic base;
        logic set;
        logic clr;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_trio(input logic [7:0] a, input logic we,
                                               input logic [7:0] base_ofs);
        wr_strobe_t s;
        s.base = we && (a == base_ofs);
        s.set  = we && (a == base_ofs + 8'h04);
        s.clr  = we && (a == base_ofs + 8'h08);
        return s;
    endfunction
endpackage

// File: rtl/pin_ctrl_field.sv
module pin_ctrl_field #(
    parameter int          W   = 32,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_base,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= RST;
        else if (wr_base) q <= wdata;
        else if (wr_set)  q <= q | wdata;
        else if (wr_clr)  q <= q & ~wdata;
    end
endmodule

// File: rtl/pin_ctrl_sync.sv
module pin_ctrl_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pin_ctrl_rdmux.sv
module pin_ctrl_rdmux
    import pin_ctrl_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [7:0]                addr,
    input  logic [W-1:0]              fn_q,
    input  logic [W-1:0]              oe_q,
    input  logic [W-1:0]              out_q,
    input  logic [W-1:0]              alt_q,
    input  logic [W-1:0]              inconn_q,
    input  logic [W-1:0]              in_sync,
    input  logic [NSTORE-1:0][W-1:0]  store_q,
    output logic [W-1:0]              rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_FN, OFS_FN_SET, OFS_FN_CLR:    rdata = fn_q;
            OFS_OE, OFS_OE_SET, OFS_OE_CLR:    rdata = oe_q;
            OFS_OUT:                           rdata = out_q;
            OFS_IN:                            rdata = in_sync & inconn_q;
            OFS_INCONN:                        rdata = inconn_q;
            OFS_ALT, OFS_ALT_SET, OFS_ALT_CLR: rdata = alt_q;
            default:                           rdata = '0;
        endcase
        for (int i = 0; i < NSTORE; i++) begin
            if (addr == STORE_OFS[i]) rdata = store_q[i];
        end
    end
endmodule

// File: rtl/pin_ctrl_bank.sv
module pin_ctrl_bank
    import pin_ctrl_pkg::*;
#(
    parameter int W         = 32,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [7:0]   addr,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pin_gpio,
    output logic [W-1:0] pin_alt_sec
);
    wr_strobe_t fn_s, oe_s, out_s, alt_s;
    logic [W-1:0] fn_q, oe_q, out_q, alt_q, inconn_q, in_sync;
    logic [NSTORE-1:0][W-1:0] store_q;

    assign fn_s  = decode_trio(addr, wr_en, OFS_FN);
    assign oe_s  = decode_trio(addr, wr_en, OFS_OE);
    assign out_s = decode_trio(addr, wr_en, OFS_OUT);
    assign alt_s = decode_trio(addr, wr_en, OFS_ALT);

    pin_ctrl_field #(.W(W), .RST({W{1'b1}})) u_fn (
        .clk(clk), .rst_n(rst_n), .wr_base(fn_s.base), .wr_set(fn_s.set),
        .wr_clr(fn_s.clr), .wdata(wdata), .q(fn_q));

    pin_ctrl_field #(.W(W), .RST('0)) u_oe (
        .clk(clk), .rst_n(rst_n), .wr_base(oe_s.base), .wr_set(oe_s.set),
        .wr_clr(oe_s.clr), .wdata(wdata), .q(oe_q));

    pin_ctrl_field #(.W(W), .RST('0)) u_out (
        .clk(clk), .rst_n(rst_n), .wr_base(out_s.base), .wr_set(out_s.set),
        .wr_clr(out_s.clr), .wdata(wdata), .q(out_q));

    pin_ctrl_field #(.W(W), .RST('0)) u_alt (
        .clk(clk), .rst_n(rst_n), .wr_base(alt_s.base), .wr_set(alt_s.set),
        .wr_clr(alt_s.clr), .wdata(wdata), .q(alt_q));

    pin_ctrl_field #(.W(W), .RST('0)) u_inconn (
        .clk(clk), .rst_n(rst_n), .wr_base(wr_en && (addr == OFS_INCONN)),
        .wr_set(1'b0), .wr_clr(1'b0), .wdata(wdata), .q(inconn_q));

    genvar i;
    generate
        for (i = 0; i < NSTORE; i++) begin : g_store
            pin_ctrl_field #(.W(W), .RST('0)) u_word (
                .clk(clk), .rst_n(rst_n), .wr_base(wr_en && (addr == STORE_OFS[i])),
                .wr_set(1'b0), .wr_clr(1'b0), .wdata(wdata), .q(store_q[i]));
        end
    endgenerate

    pin_ctrl_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_sync));

    pin_ctrl_rdmux #(.W(W)) u_rd (
        .addr(addr), .fn_q(fn_q), .oe_q(oe_q), .out_q(out_q), .alt_q(alt_q),
        .inconn_q(inconn_q), .in_sync(in_sync), .store_q(store_q), .rdata(rdata));

    assign pad_out     = out_q;
    assign pad_oe      = oe_q;
    assign pin_gpio    = fn_q;
    assign pin_alt_sec = alt_q;
endmodule

// File: rtl/pin_ctrl_bank_chk.sv
module pin_ctrl_bank_chk
    import pin_ctrl_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [7:0]   addr,
    input logic         wr_en,
    input logic [W-1:0] wdata,
    input logic [W-1:0] rdata,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pin_gpio,
    input logic [W-1:0] pin_alt_sec,
    input logic [W-1:0] inconn
);
    assert_out_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_OUT) |=> (pad_out == $past(wdata)));

    assert_oe_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_OE_SET) |=> (pad_oe == ($past(pad_oe) | $past(wdata))));

    assert_out_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_OUT_CLR) |=> (pad_out == ($past(pad_out) & ~$past(wdata))));

    assert_out_alias_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_OUT_SET || addr == OFS_OUT_CLR) |-> (rdata == '0));

    assert_in_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_IN) |-> ((rdata & ~inconn) == '0));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 8'h44 || addr == 8'h58 || addr == 8'h80) |-> (rdata == '0));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pin_gpio)
                    && $stable(pin_alt_sec)));
endmodule

bind pin_ctrl_bank pin_ctrl_bank_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe), .pin_gpio(pin_gpio),
    .pin_alt_sec(pin_alt_sec), .inconn(inconn_q));

// File: tb/tb_pin_ctrl_bank.sv
`timescale 1ns/1ps
module tb_pin_ctrl_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pad_out, pad_oe, pin_gpio, pin_alt_sec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // 200 MHz
    always #2.5 clk = ~clk;

    pin_ctrl_bank dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pin_gpio(pin_gpio), .pin_alt_sec(pin_alt_sec));

    // bench model of the registers
    logic [31:0] m_fn, m_oe, m_out, m_alt, m_conn;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic chk_pads(input string req);
        chk({req, " pad_out"}, pad_out, m_out);
        chk({req, " pad_oe"}, pad_oe, m_oe);
        chk({req, " pin_gpio"}, pin_gpio, m_fn);
        chk({req, " pin_alt_sec"}, pin_alt_sec, m_alt);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        m_fn = '1; m_oe = '0; m_out = '0; m_alt = '0; m_conn = '0;
        chk_pads("R1 reset");
        rd(8'h00, v); chk("R1 fn reset", v, 32'hFFFF_FFFF);
        rd(8'h0C, v); chk("R1 oe reset", v, 32'h0);
        rd(8'h30, v); chk("R1 inconn reset", v, 32'h0);
        rd(8'h60, v); chk("R1 store reset", v, 32'h0);
    endtask

    task automatic t_direct;
        logic [31:0] v;
        wr(8'h0C, 32'hA5A5_0F0F); m_oe = 32'hA5A5_0F0F;
        wr(8'h18, 32'h1234_5678); m_out = 32'h1234_5678;
        wr(8'h68, 32'h0000_00F0); m_alt = 32'h0000_00F0;
        wr(8'h00, 32'h0000_FFFF); m_fn = 32'h0000_FFFF;
        chk_pads("R2 direct");
        rd(8'h0C, v); chk("R2 oe readback", v, m_oe);
        rd(8'h18, v); chk("R2 out readback", v, m_out);
        rd(8'h68, v); chk("R2 alt readback", v, m_alt);
    endtask

    task automatic t_set;
        logic [31:0] v;
        wr(8'h10, 32'h0000_F0F0); m_oe  |= 32'h0000_F0F0;
        wr(8'h1C, 32'h8000_0001); m_out |= 32'h8000_0001;
        wr(8'h6C, 32'h0F00_0000); m_alt |= 32'h0F00_0000;
        wr(8'h04, 32'h0001_0000); m_fn  |= 32'h0001_0000;
        wr(8'h1C, 32'h0);
        chk_pads("R3 set alias");
        rd(8'h10, v); chk("R5 oe set reads base", v, m_oe);
        rd(8'h04, v); chk("R5 fn set reads base", v, m_fn);
        rd(8'h1C, v); chk("R5 out set reads zero", v, 32'h0);
    endtask

    task automatic t_clr;
        logic [31:0] v;
        wr(8'h14, 32'hFFFF_0000); m_oe  &= ~32'hFFFF_0000;
        wr(8'h20, 32'h0000_00FF); m_out &= ~32'h0000_00FF;
        wr(8'h70, 32'h0000_0030); m_alt &= ~32'h0000_0030;
        wr(8'h08, 32'h0000_0003); m_fn  &= ~32'h0000_0003;
        wr(8'h20, 32'h0);
        chk_pads("R4 clear alias");
        rd(8'h14, v); chk("R5 oe clr reads base", v, m_oe);
        rd(8'h70, v); chk("R5 alt clr reads base", v, m_alt);
        rd(8'h20, v); chk("R5 out clr reads zero", v, 32'h0);
    endtask

    task automatic t_input;
        logic [31:0] v;
        wr(8'h30, 32'hFFFF_FFFF); m_conn = '1;
        @(negedge clk);
        pin_in = 32'hDEAD_BEEF;
        addr = 8'h24;
        @(negedge clk);
        rd(8'h24, v); chk("R6 not yet after one edge", v, 32'h0);
        @(negedge clk);
        rd(8'h24, v); chk("R6 visible after two edges", v, 32'hDEAD_BEEF);
        wr(8'h24, 32'h0000_0000);
        rd(8'h24, v); chk("R6 write to input ignored", v, 32'hDEAD_BEEF);
        wr(8'h30, 32'h0000_FFFF); m_conn = 32'h0000_FFFF;
        rd(8'h24, v); chk("R7 gated by connect", v, 32'h0000_BEEF);
        rd(8'h30, v); chk("R2 inconn readback", v, m_conn);
        chk_pads("R6 pads untouched");
    endtask

    task automatic t_store;
        logic [31:0] v;
        wr(8'h60, 32'h1111_1111);
        wr(8'h64, 32'h2222_2222);
        wr(8'hB0, 32'h3333_3333);
        wr(8'hB4, 32'h4444_4444);
        wr(8'hB8, 32'h5555_5555);
        rd(8'h60, v); chk("R8 store 60", v, 32'h1111_1111);
        rd(8'h64, v); chk("R8 store 64", v, 32'h2222_2222);
        rd(8'hB0, v); chk("R8 store B0", v, 32'h3333_3333);
        rd(8'hB4, v); chk("R8 store B4", v, 32'h4444_4444);
        rd(8'hB8, v); chk("R8 store B8", v, 32'h5555_5555);
        chk_pads("R8 pads untouched");
    endtask

    task automatic t_reserved;
        logic [31:0] v;
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h58, 32'hFFFF_FFFF);
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h1A, 32'hFFFF_FFFF);
        rd(8'h44, v); chk("R9 reserved 44", v, 32'h0);
        rd(8'h58, v); chk("R9 reserved 58", v, 32'h0);
        rd(8'h80, v); chk("R9 reserved 80", v, 32'h0);
        rd(8'h28, v); chk("R9 unlisted 28", v, 32'h0);
        rd(8'h1A, v); chk("R9 misaligned 1A", v, 32'h0);
        rd(8'h30, v); chk("R9 inconn kept", v, m_conn);
        rd(8'h60, v); chk("R9 store kept", v, 32'h1111_1111);
        chk_pads("R9 pads untouched");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_direct;
        t_set;
        t_clr;
        t_input;
        t_store;
        t_reserved;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule